// File: doc/BRIEF.md
# RTC Timebase Prescaler and Clock-Output Selector

This block is the timebase of a real-time clock. It holds an 8-bit control register and divides an incoming time reference down to a one-cycle seconds strobe that a calendar counter elsewhere consumes. The reference is either a crystal-rate enable, prescaled to 128 events per second and then halved through a seven-stage binary chain, or a mains line pulse counted 50 or 60 times per second. All logic runs on one system clock. The crystal and line references reach it as single-cycle enables.

The same register picks one of eight square-wave sources for a clock-output pin. These are the raw crystal, three binary fractions of it, a forced low level, the 1 Hz and 2 Hz chain taps, and a last code that gives the line pulse in line mode or the 64 Hz tap in crystal mode. A run bit stops the time count by holding the chain's 32 Hz to 1 Hz stages at zero. The prescaler and the 64 Hz stage keep running, so only the two slow output taps go quiet.

Top module: `rtc_timebase`

## Requirements
- R1: After power-on reset the control register reads 0x00, so the output selects the raw crystal and the seconds strobe is low.
- R2: A write loads all eight bits, and the value reads back on the next cycle. Bit 7 is run, bit 6 is line mode (1 = line, 0 = crystal), bits 5:4 are the crystal select, bit 3 is the line rate (1 = 50, 0 = 60), and bits 2:0 are the output code.
- R3: In crystal mode the seconds strobe repeats every 128 × H crystal ticks. H is the per-select divide parameter for 128 Hz events, and crystal selects 0..3 pick the 4.194304 MHz, 2.097152 MHz, 1.048576 MHz and 32.768 kHz ratios.
- R4: In line mode the seconds strobe fires on every 60th line pulse, or on every 50th when the line-rate bit is 1.
- R5: While run is 0, no seconds strobe is produced in either mode, and the line counter is held at zero.
- R6: When run is set again, the first strobe comes one full chain second (128 events, within one event) later.
- R7: Output codes 1, 2 and 3 give the crystal divided by 2, 4 and 8. Code 0 repeats each crystal tick one cycle later.
- R8: Output code 4 holds the clock output low.
- R9: Output codes 6 and 5 give the 2 Hz and 1 Hz chain taps while running, and a low output while run is 0.
- R10: In crystal mode, output code 7 gives the 64 Hz stage, and that stage keeps toggling while run is 0.
- R11: In line mode, output code 7 repeats each line pulse one cycle later.
- R12: A write that changes the time-base bit restarts the line count and the chain's slow stages, and it suppresses any strobe in that cycle.
- R13: A change of crystal select takes effect at the next crystal tick. Strobes are then spaced by the new ratio, and the first one comes within one new second.
- R14: The seconds strobe is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register contents |
| xtal_tick | input | 1 | One-cycle enable at the crystal rate |
| line_tick | input | 1 | One-cycle enable per mains line cycle |
| sec_pulse | output | 1 | One-cycle seconds strobe |
| clk_out | output | 1 | Selected square-wave clock output |

## Verification
The seconds strobe is timed between two consecutive pulses under each of the four crystal selects. Since every select gives a different spacing, a wrong preload or a swapped select shows up as a wrong interval. Line mode is driven with counted bursts of line pulses, first 59 then one more, at both rates. A burst sent before a time-base switch separates a counter that restarts on the switch from one that only wraps. Each output code is checked by counting toggles or high cycles over a window that holds a whole number of periods, with run both set and cleared. This separates the taps that must freeze on stop from those that must keep running.

// File: rtl/rtcdiv_pkg.sv
package rtcdiv_pkg;

    // Control register layout; bit order is decoded by the divider logic.
    typedef struct packed {
        logic       run;        // bit 7
        logic       line_mode;  // bit 6
        logic [1:0] xsel;       // bits 5:4
        logic       line50;     // bit 3
        logic [2:0] osel;       // bits 2:0
    } ctl_t;

    typedef enum logic [2:0] {
        OUT_XTAL  = 3'd0,
        OUT_XDIV2 = 3'd1,
        OUT_XDIV4 = 3'd2,
        OUT_XDIV8 = 3'd3,
        OUT_OFF   = 3'd4,
        OUT_1HZ   = 3'd5,
        OUT_2HZ   = 3'd6,
        OUT_LINE  = 3'd7
    } osel_e;

    // Seven binary stages from 64 Hz down to 1 Hz.
    localparam int unsigned CHAIN_W = 7;
    localparam int unsigned XDIV_W  = 3;

endpackage

// File: rtl/rtcdiv_ctl.sv
module rtcdiv_ctl
    import rtcdiv_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ctl_t       ctl_o,
    output logic       base_switch_o
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d         = ctl_q;
        base_switch_o = 1'b0;
        if (wr_en) begin
            ctl_d         = ctl_t'(wr_data);
            base_switch_o = (wr_data[6] != ctl_q.line_mode);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/rtcdiv_xtal.sv
module rtcdiv_xtal
    import rtcdiv_pkg::*;
#(
    parameter int unsigned HALF_SEL0 = 32768,
    parameter int unsigned HALF_SEL1 = 16384,
    parameter int unsigned HALF_SEL2 = 8192,
    parameter int unsigned HALF_SEL3 = 256
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              xtal_tick,
    input  logic              run,
    input  logic              line_mode,
    input  logic [1:0]        xsel,
    input  logic              base_switch,
    output logic [XDIV_W-1:0] xdiv_nxt_o,
    output logic              tap64_nxt_o,
    output logic              tap2_nxt_o,
    output logic              tap1_nxt_o,
    output logic              sec_o
);

    localparam int unsigned MAX01    = (HALF_SEL0 > HALF_SEL1) ? HALF_SEL0 : HALF_SEL1;
    localparam int unsigned MAX23    = (HALF_SEL2 > HALF_SEL3) ? HALF_SEL2 : HALF_SEL3;
    localparam int unsigned HALF_MAX = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int unsigned PRE_W    = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

    typedef struct packed {
        logic [PRE_W-1:0]   pre;
        logic [XDIV_W-1:0]  xdiv;
        logic [CHAIN_W-1:0] chain;
    } xstate_t;

    xstate_t st_d, st_q;

    logic [31:0] limit;
    logic        pre_wrap;
    logic        ev128;

    always_comb begin
        case (xsel)
            2'd0:    limit = HALF_SEL0;
            2'd1:    limit = HALF_SEL1;
            2'd2:    limit = HALF_SEL2;
            default: limit = HALF_SEL3;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        // ">=" lets a smaller new ratio wrap at once instead of running past it
        pre_wrap = (32'(st_q.pre) + 32'd1) >= limit;
        ev128    = xtal_tick && pre_wrap;
        sec_o    = 1'b0;

        if (xtal_tick) begin
            st_d.xdiv = st_q.xdiv + XDIV_W'(1);
            if (pre_wrap) st_d.pre = '0;
            else          st_d.pre = st_q.pre + PRE_W'(1);
        end

        if (ev128) begin
            if (run) st_d.chain = st_q.chain + CHAIN_W'(1);
            else     st_d.chain = {{(CHAIN_W-1){1'b0}}, ~st_q.chain[0]};
        end else if (!run) begin
            st_d.chain = {{(CHAIN_W-1){1'b0}}, st_q.chain[0]};
        end

        if (base_switch) begin
            st_d.chain[CHAIN_W-1:1] = '0;
        end

        sec_o = ev128 && run && !line_mode && !base_switch && (&st_q.chain);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xdiv_nxt_o  = st_d.xdiv;
    assign tap64_nxt_o = st_d.chain[0];
    assign tap2_nxt_o  = st_d.chain[CHAIN_W-2];
    assign tap1_nxt_o  = st_d.chain[CHAIN_W-1];

endmodule

// File: rtl/rtcdiv_line.sv
module rtcdiv_line #(
    parameter int unsigned LINE_N50 = 50,
    parameter int unsigned LINE_N60 = 60
) (
    input  logic clk,
    input  logic por_n,
    input  logic line_tick,
    input  logic run,
    input  logic line_mode,
    input  logic line50,
    input  logic base_switch,
    output logic sec_o
);

    localparam int unsigned N_MAX = (LINE_N50 > LINE_N60) ? LINE_N50 : LINE_N60;
    localparam int unsigned CNT_W = $clog2(N_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lstate_t;

    lstate_t st_d, st_q;

    logic [31:0] n_lim;
    logic        at_end;

    always_comb begin
        n_lim  = line50 ? LINE_N50 : LINE_N60;
        at_end = (32'(st_q.cnt) + 32'd1) >= n_lim;
        st_d   = st_q;
        sec_o  = 1'b0;

        if (base_switch || !run) begin
            st_d.cnt = '0;
        end else if (line_tick) begin
            if (at_end) begin
                st_d.cnt = '0;
                sec_o    = line_mode;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rtcdiv_out.sv
module rtcdiv_out
    import rtcdiv_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [2:0]        osel,
    input  logic              line_mode,
    input  logic              xtal_tick,
    input  logic              line_tick,
    input  logic [XDIV_W-1:0] xdiv_nxt,
    input  logic              tap64_nxt,
    input  logic              tap2_nxt,
    input  logic              tap1_nxt,
    input  logic              sec_xtal,
    input  logic              sec_line,
    output logic              sec_pulse_o,
    output logic              clk_out_o
);

    typedef struct packed {
        logic sec;
        logic clk_out;
    } ostate_t;

    ostate_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sec = sec_xtal || sec_line;
        unique case (osel_e'(osel))
            OUT_XTAL:  st_d.clk_out = xtal_tick;
            OUT_XDIV2: st_d.clk_out = xdiv_nxt[0];
            OUT_XDIV4: st_d.clk_out = xdiv_nxt[1];
            OUT_XDIV8: st_d.clk_out = xdiv_nxt[2];
            OUT_OFF:   st_d.clk_out = 1'b0;
            OUT_1HZ:   st_d.clk_out = tap1_nxt;
            OUT_2HZ:   st_d.clk_out = tap2_nxt;
            OUT_LINE:  st_d.clk_out = line_mode ? line_tick : tap64_nxt;
            default:   st_d.clk_out = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sec_pulse_o = st_q.sec;
    assign clk_out_o   = st_q.clk_out;

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtcdiv_pkg::*;
#(
    parameter int unsigned HALF_SEL0 = 32768,
    parameter int unsigned HALF_SEL1 = 16384,
    parameter int unsigned HALF_SEL2 = 8192,
    parameter int unsigned HALF_SEL3 = 256,
    parameter int unsigned LINE_N50  = 50,
    parameter int unsigned LINE_N60  = 60
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       xtal_tick,
    input  logic       line_tick,
    output logic       sec_pulse,
    output logic       clk_out
);

    ctl_t              ctl;
    logic              base_switch;
    logic [XDIV_W-1:0] xdiv_nxt;
    logic              tap64_nxt;
    logic              tap2_nxt;
    logic              tap1_nxt;
    logic              sec_xtal;
    logic              sec_line;

    rtcdiv_ctl i_ctl (
        .clk           (clk),
        .por_n         (por_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .ctl_o         (ctl),
        .base_switch_o (base_switch)
    );

    rtcdiv_xtal #(
        .HALF_SEL0 (HALF_SEL0),
        .HALF_SEL1 (HALF_SEL1),
        .HALF_SEL2 (HALF_SEL2),
        .HALF_SEL3 (HALF_SEL3)
    ) i_xtal (
        .clk         (clk),
        .por_n       (por_n),
        .xtal_tick   (xtal_tick),
        .run         (ctl.run),
        .line_mode   (ctl.line_mode),
        .xsel        (ctl.xsel),
        .base_switch (base_switch),
        .xdiv_nxt_o  (xdiv_nxt),
        .tap64_nxt_o (tap64_nxt),
        .tap2_nxt_o  (tap2_nxt),
        .tap1_nxt_o  (tap1_nxt),
        .sec_o       (sec_xtal)
    );

    rtcdiv_line #(
        .LINE_N50 (LINE_N50),
        .LINE_N60 (LINE_N60)
    ) i_line (
        .clk         (clk),
        .por_n       (por_n),
        .line_tick   (line_tick),
        .run         (ctl.run),
        .line_mode   (ctl.line_mode),
        .line50      (ctl.line50),
        .base_switch (base_switch),
        .sec_o       (sec_line)
    );

    rtcdiv_out i_out (
        .clk         (clk),
        .por_n       (por_n),
        .osel        (ctl.osel),
        .line_mode   (ctl.line_mode),
        .xtal_tick   (xtal_tick),
        .line_tick   (line_tick),
        .xdiv_nxt    (xdiv_nxt),
        .tap64_nxt   (tap64_nxt),
        .tap2_nxt    (tap2_nxt),
        .tap1_nxt    (tap1_nxt),
        .sec_xtal    (sec_xtal),
        .sec_line    (sec_line),
        .sec_pulse_o (sec_pulse),
        .clk_out_o   (clk_out)
    );

    assign rd_data = ctl;

endmodule

// File: rtl/rtcdiv_checker.sv
module rtcdiv_checker (
    input logic       clk,
    input logic       por_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       sec_pulse,
    input logic       clk_out
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> (rd_data == 8'h00));

    p_write_load_r2: assert property (@(posedge clk) disable iff (!por_n)
        wr_en |=> (rd_data == $past(wr_data)));

    p_stop_no_strobe_r5: assert property (@(posedge clk) disable iff (!por_n)
        !rd_data[7] |=> !sec_pulse);

    p_off_low_r8: assert property (@(posedge clk) disable iff (!por_n)
        (rd_data[2:0] == 3'd4) |=> !clk_out);

    p_stopped_tap_low_r9: assert property (@(posedge clk) disable iff (!por_n)
        (!rd_data[7] && ((rd_data[2:0] == 3'd5) || (rd_data[2:0] == 3'd6))) |=> !clk_out);

    p_strobe_single_r14: assert property (@(posedge clk) disable iff (!por_n)
        sec_pulse |=> !sec_pulse);

endmodule

bind rtc_timebase rtcdiv_checker i_rtcdiv_checker (
    .clk       (clk),
    .por_n     (por_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .sec_pulse (sec_pulse),
    .clk_out   (clk_out)
);

// File: tb/test_rtc_timebase.sv
module test_rtc_timebase;

    localparam int unsigned H0 = 8;
    localparam int unsigned H1 = 4;
    localparam int unsigned H2 = 2;
    localparam int unsigned H3 = 1;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       xtal_tick = 1'b0;
    logic       line_tick = 1'b0;
    logic       sec_pulse;
    logic       clk_out;

    always #2 clk = ~clk;

    rtc_timebase #(
        .HALF_SEL0 (H0),
        .HALF_SEL1 (H1),
        .HALF_SEL2 (H2),
        .HALF_SEL3 (H3)
    ) i_rtc_timebase (
        .clk       (clk),
        .por_n     (por_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .xtal_tick (xtal_tick),
        .line_tick (line_tick),
        .sec_pulse (sec_pulse),
        .clk_out   (clk_out)
    );

    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    int   npulse = 0;
    int   last_p = 0;
    int   prev_p = 0;
    int   wide = 0;
    logic sec_prev = 1'b0;
    bit   done = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sec_pulse === 1'b1) begin
            npulse = npulse + 1;
            prev_p = last_p;
            last_p = cyc;
            if (sec_prev) wide = wide + 1;
        end
        sec_prev = (sec_pulse === 1'b1);
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_ctl(input logic [7:0] v);
        step();
        wr_en   = 1'b1;
        wr_data = v;
        step();
        wr_en   = 1'b0;
    endtask

    // Waits for two further strobes; returns the spacing between them.
    task automatic pulse_gap(output int gap);
        int p0 = npulse;
        for (int k = 0; k < 5000 && npulse < p0 + 2; k++) step();
        gap = (npulse >= p0 + 2) ? (last_p - prev_p) : -1;
    endtask

    task automatic count_toggles(input int w, output int t);
        logic prev;
        repeat (4) step();
        prev = clk_out;
        t = 0;
        for (int k = 0; k < w; k++) begin
            step();
            if (clk_out !== prev) t++;
            prev = clk_out;
        end
    endtask

    task automatic send_line(input int n);
        for (int k = 0; k < n; k++) begin
            step(); line_tick = 1'b1;
            step(); line_tick = 1'b0;
        end
        step();
        step();
    endtask

    task automatic t_reset();
        check("R1 reg after reset", rd_data, 0);
        check("R1 strobe after reset", sec_pulse, 0);
    endtask

    task automatic t_readback();
        write_ctl(8'hA5);
        check("R2 readback", rd_data, 8'hA5);
        write_ctl(8'h84);
        check("R2 readback", rd_data, 8'h84);
    endtask

    task automatic t_xtal_rates();
        int gap;
        xtal_tick = 1'b1;
        write_ctl(8'h84); pulse_gap(gap); check("R3 sel0 interval", gap, 128 * H0);
        write_ctl(8'h94); pulse_gap(gap); check("R3 sel1 interval", gap, 128 * H1);
        write_ctl(8'hA4); pulse_gap(gap); check("R3 sel2 interval", gap, 128 * H2);
        write_ctl(8'hB4); pulse_gap(gap); check("R3 sel3 interval", gap, 128 * H3);
    endtask

    task automatic t_ratio_change();
        int gap, c0, p0;
        write_ctl(8'h84);
        repeat (300) step();
        c0 = cyc; p0 = npulse;
        write_ctl(8'hB4);
        for (int k = 0; k < 400 && npulse == p0; k++) step();
        check_range("R13 first strobe after select change", last_p - c0, 1, 128 * H3 + 4);
        pulse_gap(gap);
        check("R13 new interval", gap, 128 * H3);
    endtask

    task automatic t_stop_start();
        int p0, c0;
        write_ctl(8'h34);
        p0 = npulse;
        repeat (300) step();
        check("R5 no strobe while stopped (crystal)", npulse - p0, 0);
        c0 = cyc;
        write_ctl(8'hB4);
        for (int k = 0; k < 400 && npulse == p0; k++) step();
        check_range("R6 first strobe after restart", last_p - c0, 126, 134);
    endtask

    task automatic t_xtal_outputs();
        int t, hi;
        write_ctl(8'hB1); count_toggles(16, t); check("R7 code1 toggles", t, 16);
        write_ctl(8'hB2); count_toggles(16, t); check("R7 code2 toggles", t, 8);
        write_ctl(8'hB3); count_toggles(16, t); check("R7 code3 toggles", t, 4);
        xtal_tick = 1'b0;
        write_ctl(8'hB0);
        step(); step();
        hi = 0;
        for (int k = 0; k < 20; k++) begin
            xtal_tick = (k % 2 == 0);
            step();
            if (clk_out === 1'b1) hi++;
        end
        xtal_tick = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            if (clk_out === 1'b1) hi++;
        end
        check("R7 code0 follows crystal ticks", hi, 10);
        xtal_tick = 1'b1;
    endtask

    task automatic t_off_and_taps();
        int t;
        write_ctl(8'hB4); count_toggles(64, t); check("R8 code4 stays low", t, 0);
        check("R8 code4 level", clk_out, 0);
        write_ctl(8'hB6); count_toggles(128, t); check("R9 2Hz tap toggles", t, 4);
        write_ctl(8'hB5); count_toggles(128, t); check("R9 1Hz tap toggles", t, 2);
        write_ctl(8'h35); count_toggles(128, t); check("R9 1Hz tap stopped", t, 0);
        check("R9 1Hz tap stopped level", clk_out, 0);
        write_ctl(8'h36); count_toggles(128, t); check("R9 2Hz tap stopped", t, 0);
        write_ctl(8'h27); count_toggles(32, t); check("R10 64Hz tap runs while stopped", t, 16);
    endtask

    task automatic t_line_mode();
        int p0, hi;
        xtal_tick = 1'b0;
        write_ctl(8'hB4);
        send_line(20);
        write_ctl(8'hC4);
        p0 = npulse;
        send_line(59);
        check("R12 no strobe before 60 after switch", npulse - p0, 0);
        send_line(1);
        check("R12 R4 strobe on 60th pulse", npulse - p0, 1);
        write_ctl(8'hCC);
        p0 = npulse;
        send_line(49);
        check("R4 no strobe before 50", npulse - p0, 0);
        send_line(1);
        check("R4 strobe on 50th pulse", npulse - p0, 1);
        write_ctl(8'hC7);
        step(); step();
        hi = 0;
        for (int k = 0; k < 10; k++) begin
            step(); line_tick = 1'b1;
            if (clk_out === 1'b1) hi++;
            step(); line_tick = 1'b0;
            if (clk_out === 1'b1) hi++;
        end
        step();
        if (clk_out === 1'b1) hi++;
        check("R11 code7 follows line pulses", hi, 10);
        write_ctl(8'h44);
        p0 = npulse;
        send_line(70);
        check("R5 no strobe while stopped (line)", npulse - p0, 0);
    endtask

    initial begin
        repeat (3) step();
        por_n = 1'b1;
        step();
        t_reset();
        t_readback();
        t_xtal_rates();
        t_ratio_change();
        t_stop_start();
        t_xtal_outputs();
        t_off_and_taps();
        t_line_mode();
        check("R14 strobe width one cycle", wide, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule